// File: doc/BRIEF.md
# Extension Instruction Takeover Controller

This block sits beside the decode stage of a five-stage in-order pipeline and looks at every instruction that reaches decode. When the top six bits of a valid instruction equal the opcode this extension has been configured to claim, and the extension fabric is loaded, the block takes over. In that same cycle it latches the two source register values that decode has already fetched, together with the 16-bit immediate. It then runs a fixed number of execute cycles that stand in for the accelerator datapath. Instructions younger than the extension are held in decode until the extension is one cycle from finishing.

While it runs, the block tracks the instructions that were issued before the extension as they drain through the memory and write-back stages. It grants itself the memory port and the register-file write ports only after those older instructions have left the matching stage. It also issues one far register read for a register not encoded in the instruction, and collects the result after the fixed register-file latency.

When the fabric is not loaded, or another opcode is seen, nothing is claimed. The pipeline then treats the word as a no-operation, and the original code that follows it runs in software.

Top module: `ext_takeover`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release with `id_valid` low, every output is zero.
- R2: `claim_o` is high in the same cycle as decode when `id_valid` is high, `id_instr[31:26]` equals `MATCH_OP`, `ext_present` is high and the block is idle. Any other opcode is never claimed.
- R3: With `ext_present` low, a matching word is not claimed and `busy_o` stays low, so the word acts as a no-operation.
- R4: On a claim, `op_rs_o` and `op_rt_o` take `id_rs_val` and `id_rt_val`, and `op_imm_o` takes `id_instr[15:0]`. All three hold steady until the next claim.
- R5: Counting the cycle after the claim as execute cycle 1, `stall_o` is high in execute cycles 1 to `EXEC_CYCLES-2` and low from cycle `EXEC_CYCLES-1` on.
- R6: `busy_o` is high in execute cycles 1 to `EXEC_CYCLES`. `done_o` is high only in cycle `EXEC_CYCLES`.
- R7: `mport_grant_o` is high while busy, except when an instruction issued earlier occupies the memory stage. With two valid instructions directly ahead of the extension, the first grant comes in execute cycle 2.
- R8: `wport_grant_o` is high while busy, except when an earlier instruction occupies the write-back stage. With two valid instructions directly ahead, the first grant comes in execute cycle 3. With no instructions ahead, it comes in execute cycle 1.
- R9: `far_req_o` pulses in execute cycle 1 with `far_addr_o` equal to `op_imm_o[4:0]`. `far_data` is sampled in execute cycle `RD_LAT` (4 by default). `far_vld_o` is high from cycle `RD_LAT+1` while busy, and `far_val_o` then shows the sampled value.
- R10: While busy, a matching word in decode is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_instr | input | 32 | Instruction word in decode |
| id_rs_val | input | DATA_W | Value read ahead for the register in bits 25:21 |
| id_rt_val | input | DATA_W | Value read ahead for the register in bits 20:16 |
| ext_present | input | 1 | Extension fabric is loaded |
| far_data | input | DATA_W | Return data of the far register read |
| claim_o | output | 1 | Decode word is taken by the extension |
| busy_o | output | 1 | Extension is executing |
| stall_o | output | 1 | Hold younger instructions in decode |
| done_o | output | 1 | Last execute cycle |
| mport_grant_o | output | 1 | Extension may use the memory port |
| wport_grant_o | output | 1 | Extension may use the register write ports |
| op_rs_o | output | DATA_W | Latched first source value |
| op_rt_o | output | DATA_W | Latched second source value |
| op_imm_o | output | 16 | Latched immediate |
| far_req_o | output | 1 | Far register read request |
| far_addr_o | output | 5 | Far register number |
| far_val_o | output | DATA_W | Far register value |
| far_vld_o | output | 1 | Far register value is valid |

## Verification
The claim is combinational, so it is due in the decode cycle itself. Busy, stall, done, both grants and the latched operands change at the first rising edge after the claim. The far value is due `RD_LAT+1` edges after it. The bench drives inputs on the falling edge and compares every output 1 ns later against a cycle model that advances on the same rising edges, so each result is checked in exactly the cycle it is due. Directed sequences then pin the first grant cycles, the stall release, the done cycle and the far-read timing to absolute execute-cycle numbers.

// File: rtl/ext_takeover_pkg.sv
// Package: shared instruction-field layout for the takeover controller.
// Assumes a 32-bit word with the opcode in the top six bits and the two
// source register numbers and the immediate below it.
package ext_takeover_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [IMM_W-1:0] imm;
    } ifmt_t;

    // Split a raw word into its immediate-format fields.
    function automatic ifmt_t split_word(input logic [INSTR_W-1:0] w);
        return ifmt_t'(w);
    endfunction

endpackage

// File: rtl/ext_decode.sv
// Module: ext_decode
// Watches the decode stage and raises a claim for the configured opcode.
// Assumes the block is loaded (ext_present) and idle before it claims.
// Otherwise the word falls through as a no-operation.
module ext_decode
    import ext_takeover_pkg::*;
#(
    parameter logic [OPC_W-1:0] MATCH_OP = 6'h1E
) (
    input  logic               id_valid,
    input  logic [INSTR_W-1:0] id_instr,
    input  logic               ext_present,
    input  logic               busy,
    output logic               claim,
    output logic [IMM_W-1:0]   imm
);

    ifmt_t fields;

    // Field split and claim decision, purely combinational.
    always_comb begin
        fields = split_word(id_instr);
        imm    = fields.imm;
        claim  = id_valid && ext_present && !busy && (fields.opc == MATCH_OP);
    end

endmodule

// File: rtl/ext_seq.sv
// Module: ext_seq
// Execute-cycle sequencer that replaces the accelerator datapath.
// It counts 1..EXEC_CYCLES after a claim, releases the stall two cycles
// before the end and flags the last cycle. Assumes EXEC_CYCLES >= 3.
module ext_seq #(
    parameter int EXEC_CYCLES = 8,
    parameter int CNT_W       = $clog2(EXEC_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             stall,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(EXEC_CYCLES);
    localparam logic [CNT_W-1:0] HOLD_END  = CNT_W'(EXEC_CYCLES - 2);

    // Step counter: load on claim, advance while busy, clear after the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (claim) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(1);
        end else if (busy) begin
            if (cnt == LAST_STEP) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Stall and completion flags from the step count.
    always_comb begin
        stall = busy && (cnt <= HOLD_END);
        done  = busy && (cnt == LAST_STEP);
    end

endmodule

// File: rtl/ext_retire.sv
// Module: ext_retire
// Follows the instructions issued ahead of the extension through the
// memory and write-back stages, and grants the shared ports once those
// stages hold no older instruction. Assumes the stages advance every
// cycle and that only decode is held by the stall.
module ext_retire (
    input  logic clk,
    input  logic rst_n,
    input  logic id_valid,
    input  logic claim,
    input  logic stall,
    input  logic busy,
    output logic mport_grant,
    output logic wport_grant
);

    logic ex_v;
    logic ma_v;
    logic older_ma;
    logic older_wb;

    // Occupancy of the execute and memory stages by ordinary instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_v <= 1'b0;
            ma_v <= 1'b0;
        end else begin
            ex_v <= id_valid && !claim && !stall;
            ma_v <= ex_v;
        end
    end

    // Snapshot of older instructions at takeover, shifted towards retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_ma <= 1'b0;
            older_wb <= 1'b0;
        end else if (claim) begin
            older_ma <= ex_v;
            older_wb <= ma_v;
        end else begin
            older_ma <= 1'b0;
            older_wb <= older_ma;
        end
    end

    // Port grants once the matching stage is free of older work.
    always_comb begin
        mport_grant = busy && !older_ma;
        wport_grant = busy && !older_wb;
    end

endmodule

// File: rtl/ext_capture.sv
// Module: ext_capture
// Latches the read-ahead operands and the immediate at takeover. It also
// issues one far register read and collects its result RD_LAT cycles
// after the claim. Assumes RD_LAT < EXEC_CYCLES.
module ext_capture
    import ext_takeover_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RD_LAT = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic [DATA_W-1:0] id_rs_val,
    input  logic [DATA_W-1:0] id_rt_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              busy,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] far_data,
    output logic [DATA_W-1:0] op_rs,
    output logic [DATA_W-1:0] op_rt,
    output logic [IMM_W-1:0]  op_imm,
    output logic              far_req,
    output logic [REG_W-1:0]  far_addr,
    output logic [DATA_W-1:0] far_val,
    output logic              far_vld
);

    localparam logic [CNT_W-1:0] SAMPLE_STEP = CNT_W'(RD_LAT);

    // Operand latch, loaded only when the word is claimed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_rs  <= '0;
            op_rt  <= '0;
            op_imm <= '0;
        end else if (claim) begin
            op_rs  <= id_rs_val;
            op_rt  <= id_rt_val;
            op_imm <= imm;
        end
    end

    // Far read result latch, sampled in the step that matches the latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            far_val <= '0;
        end else if (busy && (cnt == SAMPLE_STEP)) begin
            far_val <= far_data;
        end
    end

    // Request pulse, register number and validity window of the far read.
    always_comb begin
        far_req  = busy && (cnt == CNT_W'(1));
        far_addr = op_imm[REG_W-1:0];
        far_vld  = busy && (cnt > SAMPLE_STEP);
    end

endmodule

// File: rtl/ext_takeover.sv
// Module: ext_takeover
// Top level of the takeover controller. It ties the decode claim, the
// step sequencer, the retirement tracker and the operand capture
// together. No datapath lives here: the execute phase is a fixed count.
module ext_takeover
    import ext_takeover_pkg::*;
#(
    parameter int               DATA_W      = 32,
    parameter int               EXEC_CYCLES = 8,
    parameter int               RD_LAT      = 4,
    parameter logic [OPC_W-1:0] MATCH_OP    = 6'h1E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_valid,
    input  logic [INSTR_W-1:0] id_instr,
    input  logic [DATA_W-1:0]  id_rs_val,
    input  logic [DATA_W-1:0]  id_rt_val,
    input  logic               ext_present,
    input  logic [DATA_W-1:0]  far_data,
    output logic               claim_o,
    output logic               busy_o,
    output logic               stall_o,
    output logic               done_o,
    output logic               mport_grant_o,
    output logic               wport_grant_o,
    output logic [DATA_W-1:0]  op_rs_o,
    output logic [DATA_W-1:0]  op_rt_o,
    output logic [IMM_W-1:0]   op_imm_o,
    output logic               far_req_o,
    output logic [REG_W-1:0]   far_addr_o,
    output logic [DATA_W-1:0]  far_val_o,
    output logic               far_vld_o
);

    localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

    logic             claim;
    logic             busy;
    logic             stall;
    logic [CNT_W-1:0] cnt;
    logic [IMM_W-1:0] imm;

    ext_decode #(.MATCH_OP(MATCH_OP)) u_decode (
        .id_valid    (id_valid),
        .id_instr    (id_instr),
        .ext_present (ext_present),
        .busy        (busy),
        .claim       (claim),
        .imm         (imm)
    );

    ext_seq #(.EXEC_CYCLES(EXEC_CYCLES), .CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .claim (claim),
        .busy  (busy),
        .cnt   (cnt),
        .stall (stall),
        .done  (done_o)
    );

    ext_retire u_retire (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_valid    (id_valid),
        .claim       (claim),
        .stall       (stall),
        .busy        (busy),
        .mport_grant (mport_grant_o),
        .wport_grant (wport_grant_o)
    );

    ext_capture #(.DATA_W(DATA_W), .RD_LAT(RD_LAT), .CNT_W(CNT_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (claim),
        .id_rs_val (id_rs_val),
        .id_rt_val (id_rt_val),
        .imm       (imm),
        .busy      (busy),
        .cnt       (cnt),
        .far_data  (far_data),
        .op_rs     (op_rs_o),
        .op_rt     (op_rt_o),
        .op_imm    (op_imm_o),
        .far_req   (far_req_o),
        .far_addr  (far_addr_o),
        .far_val   (far_val_o),
        .far_vld   (far_vld_o)
    );

    // Drive the top-level status outputs from the shared nets.
    always_comb begin
        claim_o = claim;
        busy_o  = busy;
        stall_o = stall;
    end

endmodule

// File: rtl/ext_takeover_chk.sv
// Module: ext_takeover_chk
// Protocol checker for the takeover controller, bound to its top level.
module ext_takeover_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_present,
    input logic              claim_o,
    input logic              busy_o,
    input logic              stall_o,
    input logic              done_o,
    input logic              mport_grant_o,
    input logic              wport_grant_o,
    input logic [DATA_W-1:0] op_rs_o,
    input logic [15:0]       op_imm_o,
    input logic              far_req_o,
    input logic              far_vld_o
);

    // R2: a claim starts a busy, stalling window on the next edge
    p_claim_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |=> (busy_o && stall_o));

    // R3: an absent fabric never claims
    p_absent_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_present |-> !claim_o);

    // R4: latched operands hold while busy without a new claim
    p_operands_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(claim_o)) |-> ($stable(op_rs_o) && $stable(op_imm_o)));

    // R5: stall only inside the busy window
    p_stall_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> busy_o);

    // R6: the done cycle is the last busy cycle
    p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R7: memory grant only while busy
    p_mport_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mport_grant_o |-> busy_o);

    // R8: write grant only while busy
    p_wport_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wport_grant_o |-> busy_o);

    // R9: far request is a single pulse and never overlaps valid data
    p_far_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        far_req_o |=> !far_req_o);

    p_far_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        far_req_o |-> !far_vld_o);

    // R10: no claim while busy
    p_no_reclaim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !claim_o);

endmodule

bind ext_takeover ext_takeover_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_present   (ext_present),
    .claim_o       (claim_o),
    .busy_o        (busy_o),
    .stall_o       (stall_o),
    .done_o        (done_o),
    .mport_grant_o (mport_grant_o),
    .wport_grant_o (wport_grant_o),
    .op_rs_o       (op_rs_o),
    .op_imm_o      (op_imm_o),
    .far_req_o     (far_req_o),
    .far_vld_o     (far_vld_o)
);

// File: tb/tb_ext_takeover.sv
// Bench for the takeover controller: a cycle model built from the
// requirements, random decode traffic and directed corner cases.
module tb_ext_takeover;

    localparam int          DW   = 32;
    localparam int          N    = 8;
    localparam int          LAT  = 4;
    localparam logic [5:0]  OP   = 6'h1E;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_valid = 1'b0;
    logic [31:0]   id_instr = '0;
    logic [DW-1:0] id_rs_val = '0;
    logic [DW-1:0] id_rt_val = '0;
    logic          ext_present = 1'b0;
    logic [DW-1:0] far_data = '0;

    logic          claim_o, busy_o, stall_o, done_o;
    logic          mport_grant_o, wport_grant_o;
    logic [DW-1:0] op_rs_o, op_rt_o, far_val_o;
    logic [15:0]   op_imm_o;
    logic          far_req_o, far_vld_o;
    logic [4:0]    far_addr_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ext_takeover #(.DATA_W(DW), .EXEC_CYCLES(N), .RD_LAT(LAT), .MATCH_OP(OP)) dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_instr(id_instr),
        .id_rs_val(id_rs_val), .id_rt_val(id_rt_val), .ext_present(ext_present),
        .far_data(far_data), .claim_o(claim_o), .busy_o(busy_o), .stall_o(stall_o),
        .done_o(done_o), .mport_grant_o(mport_grant_o), .wport_grant_o(wport_grant_o),
        .op_rs_o(op_rs_o), .op_rt_o(op_rt_o), .op_imm_o(op_imm_o),
        .far_req_o(far_req_o), .far_addr_o(far_addr_o), .far_val_o(far_val_o),
        .far_vld_o(far_vld_o)
    );

    // Reference model state
    logic          m_busy, m_exv, m_mav, m_oma, m_owb;
    int            m_cnt;
    logic [DW-1:0] m_rs, m_rt, m_far;
    logic [15:0]   m_imm;

    function automatic bit f_claim();
        return id_valid && ext_present && !m_busy && (id_instr[31:26] == OP);
    endfunction

    function automatic bit f_stall();
        return m_busy && (m_cnt <= N - 2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_cnt <= 0; m_exv <= 0; m_mav <= 0;
            m_oma <= 0; m_owb <= 0; m_rs <= '0; m_rt <= '0; m_imm <= '0; m_far <= '0;
        end else begin
            m_exv <= id_valid && !f_claim() && !f_stall();
            m_mav <= m_exv;
            if (m_busy && m_cnt == LAT) m_far <= far_data;
            if (f_claim()) begin
                m_busy <= 1; m_cnt <= 1; m_oma <= m_exv; m_owb <= m_mav;
                m_rs <= id_rs_val; m_rt <= id_rt_val; m_imm <= id_instr[15:0];
            end else begin
                m_oma <= 0; m_owb <= m_oma;
                if (m_busy) begin
                    if (m_cnt == N) begin m_busy <= 0; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model for the current cycle.
    task automatic cmp_all();
        chk("R2 claim", DW'(claim_o), DW'(f_claim()));
        chk("R6 busy", DW'(busy_o), DW'(m_busy));
        chk("R6 done", DW'(done_o), DW'(m_busy && m_cnt == N));
        chk("R5 stall", DW'(stall_o), DW'(f_stall()));
        chk("R7 mport", DW'(mport_grant_o), DW'(m_busy && !m_oma));
        chk("R8 wport", DW'(wport_grant_o), DW'(m_busy && !m_owb));
        chk("R9 far_req", DW'(far_req_o), DW'(m_busy && m_cnt == 1));
        chk("R9 far_vld", DW'(far_vld_o), DW'(m_busy && m_cnt > LAT));
        if (m_busy) begin
            chk("R4 op_rs", op_rs_o, m_rs);
            chk("R4 op_rt", op_rt_o, m_rt);
            chk("R4 op_imm", DW'(op_imm_o), DW'(m_imm));
            chk("R9 far_addr", DW'(far_addr_o), DW'(m_imm[4:0]));
        end
        if (m_busy && m_cnt > LAT) chk("R9 far_val", far_val_o, m_far);
    endtask

    task automatic cyc(input logic v, input logic [31:0] ins, input logic [DW-1:0] rs,
                       input logic [DW-1:0] rt, input logic pres, input logic [DW-1:0] fd);
        @(negedge clk);
        id_valid = v; id_instr = ins; id_rs_val = rs; id_rt_val = rt;
        ext_present = pres; far_data = fd;
        #1;
        cmp_all();
    endtask

    function automatic logic [31:0] ext_word(input logic [15:0] imm);
        return {OP, 5'd3, 5'd4, imm};
    endfunction

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) begin
            @(negedge clk); #1;
            chk("R1 busy", DW'(busy_o), 0);
            chk("R1 stall", DW'(stall_o), 0);
            chk("R1 grants", DW'({mport_grant_o, wport_grant_o}), 0);
            chk("R1 done/far", DW'({done_o, far_req_o, far_vld_o, claim_o}), 0);
        end
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 out after reset", DW'({busy_o, stall_o, done_o, claim_o, far_vld_o}), 0);

        // R7 R8: two valid instructions ahead, then takeover
        cyc(1, 32'h0000_0021, 0, 0, 1, 0);
        cyc(1, 32'h0000_0025, 0, 0, 1, 0);
        cyc(1, ext_word(16'h0013), 32'h1111_0000, 32'h2222_0000, 1, 0);
        chk("R2 directed claim", DW'(claim_o), 1);
        for (int k = 1; k <= N; k++) begin
            cyc(1, ext_word(16'h0007), 0, 0, 1, (k == LAT) ? 32'hCAFE_F00D : 32'h0);
            if (k == 1) begin
                chk("R7 no mport EX1", DW'(mport_grant_o), 0);
                chk("R8 no wport EX1", DW'(wport_grant_o), 0);
                chk("R9 far_req EX1", DW'(far_req_o), 1);
                chk("R9 far_addr", DW'(far_addr_o), 19);
                chk("R10 no claim busy", DW'(claim_o), 0);
                chk("R4 rs latched", op_rs_o, 32'h1111_0000);
            end
            if (k == 2) begin
                chk("R7 mport EX2", DW'(mport_grant_o), 1);
                chk("R8 no wport EX2", DW'(wport_grant_o), 0);
            end
            if (k == 3) chk("R8 wport EX3", DW'(wport_grant_o), 1);
            if (k == N - 2) chk("R5 stall EX n-2", DW'(stall_o), 1);
            if (k == N - 1) chk("R5 release EX n-1", DW'(stall_o), 0);
            if (k == LAT + 1) chk("R9 far value", far_val_o, 32'hCAFE_F00D);
            chk("R6 done only last", DW'(done_o), DW'(k == N));
        end
        cyc(0, 0, 0, 0, 1, 0);
        chk("R6 idle after", DW'(busy_o), 0);

        // R8: no instructions ahead gives both grants in EX1
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, ext_word(16'h0001), 5, 6, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R8 wport EX1 bubbles", DW'(wport_grant_o), 1);
        chk("R7 mport EX1 bubbles", DW'(mport_grant_o), 1);
        for (int k = 2; k <= N; k++) cyc(0, 0, 0, 0, 1, 0);

        // R3: fabric absent, matching word is a no-operation
        cyc(1, ext_word(16'h00FF), 9, 9, 0, 0);
        chk("R3 no claim absent", DW'(claim_o), 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R3 stays idle", DW'(busy_o), 0);

        // Random decode traffic
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] opc;
            opc = ($urandom % 4 == 0) ? OP : 6'($urandom);
            cyc(($urandom % 5) != 0, {opc, 26'($urandom)}, $urandom, $urandom,
                ($urandom % 8) != 0, $urandom);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule